// File: doc/BRIEF.md
# Memory Image Checksum Engine

This engine produces a 16-bit integrity sum for a device memory image. It reads the image through a synchronous read port that has a fixed one-cycle latency. The image has three regions: program words, configuration bytes and ID words. A one-cycle start pulse begins a walk that issues one address per cycle.

The walk covers every program word first. Words that belong to a block whose code-protect flag is set count as zero. Next come the configuration bytes, and each one is ANDed with its own mask, so only implemented bits are counted. Last come the ID words, which are fetched and added only when at least one program block is protected. When the last returned word has been added, the engine raises `done` and holds the results until the next accepted start.

Next to the protection-aware sum, the engine also keeps an unprotected sum. This sum counts every program word and the masked configuration bytes, ignores protection and leaves out the ID words. It is presented as a 32-bit ID value with the sum in the upper half.

Top module: `image_checksum`

## Requirements
- R1: Every program word, at addresses 0 to NUM_BLOCKS*BLOCK_WORDS-1, is read with region code 0 on `mem_rd_sel` and added to `checksum`.
- R2: All sums are kept modulo 2^16. Carries out of bit 15 are discarded.
- R3: A configuration byte is read with region code 1 at byte offset i. It is taken from `mem_rd_data[7:0]`, ANDed with `CFG_MASK[8*i+7:8*i]` and then added. `mem_rd_data[15:8]` and any bit cleared in the mask never affect the sum.
- R4: Program words at addresses b*BLOCK_WORDS to (b+1)*BLOCK_WORDS-1 add zero to `checksum` when `cp_block[b]` is 1.
- R5: ID words are read with region code 2 and added only when at least one bit of the sampled protect vector is set. Otherwise no ID read is issued.
- R6: `id_packed` equals {U, 16'h0000}. U is the 16-bit sum of all program words, ignoring protection, plus the masked configuration bytes. U never includes ID words.
- R7: Reads are issued back to back with no gaps, in region order program, configuration, ID, and in rising address order starting at 0. `done` rises N+1 cycles after the edge that accepts start, where N is the number of reads.
- R8: `done`, `checksum` and `id_packed` hold their values until the next accepted start.
- R9: A start pulse seen while `busy` is high is ignored, and the run in progress is not disturbed.
- R10: An accepted start clears both sums and samples `cp_block`. Later changes to `cp_block` have no effect on that run.
- R11: After reset, `busy`, `done`, `mem_rd_en`, `checksum` and `id_packed` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a walk; accepted only when not busy |
| cp_block | input | NUM_BLOCKS | Code-protect flag per program block, sampled at start |
| mem_rd_en | output | 1 | Read request this cycle |
| mem_rd_sel | output | 2 | Region: 0 program, 1 configuration, 2 ID |
| mem_rd_addr | output | AW | Word or byte offset within the region |
| mem_rd_data | input | 16 | Read data, valid one cycle after the request |
| busy | output | 1 | Walk in progress, including the final drain cycle |
| done | output | 1 | Results valid; held until the next accepted start |
| checksum | output | 16 | Protection-aware sum |
| id_packed | output | 32 | Unprotected sum in bits 31:16, zeros below |

## Verification
The assertions assume that the read port returns data exactly one cycle after every request, and that `start` is a clean synchronous pulse, so `busy` can only rise after an accepted start. The bench memory model registers its output on every requested address. When no read is requested, it drives a nonzero filler value, so a pipeline that adds a word outside its slot would show up as an error. Start pulses are driven on falling edges. The one deliberate start issued during a run is timed well inside the program phase, together with a change of the protect vector.

// File: rtl/ckm_pkg.sv
package ckm_pkg;

    typedef enum logic [1:0] {
        RGN_PROG = 2'd0,
        RGN_CFG  = 2'd1,
        RGN_ID   = 2'd2,
        RGN_NONE = 2'd3
    } region_e;

    typedef enum logic [2:0] {
        PH_IDLE  = 3'd0,
        PH_PROG  = 3'd1,
        PH_CFG   = 3'd2,
        PH_ID    = 3'd3,
        PH_DRAIN = 3'd4,
        PH_DONE  = 3'd5
    } phase_e;

    // Term added to the protection-aware sum, and term added to the unprotected sum
    typedef struct packed {
        logic [15:0] guarded;
        logic [15:0] raw;
    } addend_t;

    function automatic int unsigned width_for(input int unsigned n);
        return (n <= 1) ? 1 : $clog2(n);
    endfunction

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic [15:0] cfg_term(input logic [15:0] word, input logic [7:0] mask);
        return {8'h00, word[7:0] & mask};
    endfunction

endpackage

// File: rtl/ckm_walker.sv
module ckm_walker
    import ckm_pkg::*;
#(
    parameter int unsigned NUM_BLOCKS  = 4,
    parameter int unsigned BLOCK_WORDS = 16,
    parameter int unsigned CFG_BYTES   = 8,
    parameter int unsigned ID_WORDS    = 4,
    parameter int unsigned AW          = 6
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [NUM_BLOCKS-1:0] cp_block,
    output logic                  accept,
    output logic [NUM_BLOCKS-1:0] cp_q,
    output logic                  rd_en,
    output region_e               rd_sel,
    output logic [AW-1:0]         rd_addr,
    output logic                  busy,
    output logic                  done
);

    localparam int unsigned PROG_WORDS = NUM_BLOCKS * BLOCK_WORDS;
    localparam logic [AW-1:0] LAST_PROG = AW'(PROG_WORDS - 1);
    localparam logic [AW-1:0] LAST_CFG  = AW'(CFG_BYTES - 1);
    localparam logic [AW-1:0] LAST_ID   = AW'(ID_WORDS - 1);

    phase_e        phase;
    logic [AW-1:0] idx;

    assign accept = start && (phase == PH_IDLE || phase == PH_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            idx   <= '0;
            cp_q  <= '0;
        end else if (accept) begin
            phase <= PH_PROG;
            idx   <= '0;
            cp_q  <= cp_block;
        end else begin
            case (phase)
                PH_PROG: begin
                    if (idx == LAST_PROG) begin
                        phase <= PH_CFG;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_CFG: begin
                    if (idx == LAST_CFG) begin
                        phase <= (|cp_q) ? PH_ID : PH_DRAIN;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_ID: begin
                    if (idx == LAST_ID) begin
                        phase <= PH_DRAIN;
                        idx   <= '0;
                    end else begin
                        idx <= idx + 1'b1;
                    end
                end
                PH_DRAIN: phase <= PH_DONE;
                default:  phase <= phase;
            endcase
        end
    end

    always_comb begin
        case (phase)
            PH_PROG: rd_sel = RGN_PROG;
            PH_CFG:  rd_sel = RGN_CFG;
            PH_ID:   rd_sel = RGN_ID;
            default: rd_sel = RGN_NONE;
        endcase
    end

    assign rd_en   = (phase == PH_PROG) || (phase == PH_CFG) || (phase == PH_ID);
    assign rd_addr = idx;
    assign busy    = rd_en || (phase == PH_DRAIN);
    assign done    = (phase == PH_DONE);

    // R5: the ID region is fetched only under protection
    p_id_gated_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_sel == RGN_ID) |-> (|cp_q));

    // R7: consecutive reads within a region step by one address
    p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en) && rd_sel == $past(rd_sel)) |-> (rd_addr == $past(rd_addr) + 1'b1));

    // R8: done stays up until a start arrives
    p_done_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (done && !start) |=> done);

    // R9: a walk only begins from a start request
    p_busy_needs_start_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));

    // R10: the sampled protect vector is frozen for the whole walk
    p_cp_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cp_q));

endmodule

// File: rtl/ckm_contrib.sv
module ckm_contrib
    import ckm_pkg::*;
#(
    parameter int unsigned           NUM_BLOCKS  = 4,
    parameter int unsigned           BLOCK_WORDS = 16,
    parameter int unsigned           CFG_BYTES   = 8,
    parameter int unsigned           AW          = 6,
    parameter logic [CFG_BYTES*8-1:0] CFG_MASK   = '1
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rd_en,
    input  region_e               rd_sel,
    input  logic [AW-1:0]         rd_addr,
    input  logic [15:0]           rd_data,
    input  logic [NUM_BLOCKS-1:0] cp_q,
    output logic                  add_v,
    output addend_t               add
);

    localparam int unsigned BIW = width_for(NUM_BLOCKS);
    localparam int unsigned CIW = width_for(CFG_BYTES);

    // Request tag that travels with the one-cycle read latency
    logic          v_q;
    region_e       sel_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            v_q    <= 1'b0;
            sel_q  <= RGN_NONE;
            addr_q <= '0;
        end else begin
            v_q    <= rd_en;
            sel_q  <= rd_sel;
            addr_q <= rd_addr;
        end
    end

    logic [7:0] mask_tbl [CFG_BYTES];
    for (genvar g = 0; g < CFG_BYTES; g++) begin : g_mask
        assign mask_tbl[g] = CFG_MASK[g*8 +: 8];
    end

    logic [AW-1:0]  blk_full;
    logic [BIW-1:0] blk;
    logic           blk_protected;
    logic [7:0]     cur_mask;

    assign blk_full      = addr_q / AW'(BLOCK_WORDS);
    assign blk           = blk_full[BIW-1:0];
    assign blk_protected = cp_q[blk];
    assign cur_mask      = mask_tbl[addr_q[CIW-1:0]];

    always_comb begin
        add = '0;
        case (sel_q)
            RGN_PROG: begin
                add.raw     = rd_data;
                add.guarded = blk_protected ? 16'h0000 : rd_data;
            end
            RGN_CFG: begin
                add.raw     = cfg_term(rd_data, cur_mask);
                add.guarded = cfg_term(rd_data, cur_mask);
            end
            RGN_ID: begin
                add.raw     = 16'h0000;
                add.guarded = rd_data;
            end
            default: add = '0;
        endcase
    end

    assign add_v = v_q;

    // R3: a configuration byte lands identically in both sums
    p_cfg_both_r3: assert property (@(posedge clk) disable iff (rst)
        (add_v && sel_q == RGN_CFG) |-> (add.raw == add.guarded && add.raw[15:8] == 8'h00));

    // R6: ID words never reach the unprotected sum
    p_id_not_raw_r6: assert property (@(posedge clk) disable iff (rst)
        (add_v && sel_q == RGN_ID) |-> (add.raw == 16'h0000));

endmodule

// File: rtl/ckm_accum.sv
module ckm_accum
    import ckm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        clear,
    input  logic        add_v,
    input  addend_t     add,
    output logic [15:0] sum_q,
    output logic [15:0] raw_q
);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            sum_q <= '0;
            raw_q <= '0;
        end else if (add_v) begin
            sum_q <= sum_q + add.guarded;
            raw_q <= raw_q + add.raw;
        end
    end

    // R10: an accepted start leaves both sums at zero
    p_clear_on_start_r10: assert property (@(posedge clk) disable iff (rst)
        clear |=> (sum_q == 16'h0000 && raw_q == 16'h0000));

endmodule

// File: rtl/image_checksum.sv
module image_checksum
    import ckm_pkg::*;
#(
    parameter int unsigned            NUM_BLOCKS  = 4,
    parameter int unsigned            BLOCK_WORDS = 16,
    parameter int unsigned            CFG_BYTES   = 8,
    parameter int unsigned            ID_WORDS    = 4,
    parameter logic [CFG_BYTES*8-1:0] CFG_MASK    = 64'hC5_0F_FF_01_87_3F_1F_CF,
    localparam int unsigned           PROG_WORDS  = NUM_BLOCKS * BLOCK_WORDS,
    localparam int unsigned           AW          = width_for(max3(PROG_WORDS, CFG_BYTES, ID_WORDS))
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [NUM_BLOCKS-1:0] cp_block,
    output logic                  mem_rd_en,
    output logic [1:0]            mem_rd_sel,
    output logic [AW-1:0]         mem_rd_addr,
    input  logic [15:0]           mem_rd_data,
    output logic                  busy,
    output logic                  done,
    output logic [15:0]           checksum,
    output logic [31:0]           id_packed
);

    logic                  accept;
    logic [NUM_BLOCKS-1:0] cp_q;
    region_e               rd_sel;
    logic                  add_v;
    addend_t               add;
    logic [15:0]           sum_q;
    logic [15:0]           raw_q;

    ckm_walker #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLOCK_WORDS(BLOCK_WORDS),
        .CFG_BYTES  (CFG_BYTES),
        .ID_WORDS   (ID_WORDS),
        .AW         (AW)
    ) u_walker (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .cp_block(cp_block),
        .accept  (accept),
        .cp_q    (cp_q),
        .rd_en   (mem_rd_en),
        .rd_sel  (rd_sel),
        .rd_addr (mem_rd_addr),
        .busy    (busy),
        .done    (done)
    );

    ckm_contrib #(
        .NUM_BLOCKS (NUM_BLOCKS),
        .BLOCK_WORDS(BLOCK_WORDS),
        .CFG_BYTES  (CFG_BYTES),
        .AW         (AW),
        .CFG_MASK   (CFG_MASK)
    ) u_contrib (
        .clk    (clk),
        .rst    (rst),
        .rd_en  (mem_rd_en),
        .rd_sel (rd_sel),
        .rd_addr(mem_rd_addr),
        .rd_data(mem_rd_data),
        .cp_q   (cp_q),
        .add_v  (add_v),
        .add    (add)
    );

    ckm_accum u_accum (
        .clk  (clk),
        .rst  (rst),
        .clear(accept),
        .add_v(add_v),
        .add  (add),
        .sum_q(sum_q),
        .raw_q(raw_q)
    );

    assign mem_rd_sel = rd_sel;
    assign checksum   = sum_q;
    assign id_packed  = {raw_q, 16'h0000};

    // R11: nothing is requested or reported straight after reset
    p_reset_quiet_r11: assert property (@(posedge clk)
        $past(rst) |-> (!mem_rd_en && !busy && !done && checksum == 16'h0000));

endmodule

// File: tb/tb_image_checksum.sv
module tb_image_checksum;

    localparam int unsigned NB   = 4;
    localparam int unsigned BW   = 16;
    localparam int unsigned CB   = 8;
    localparam int unsigned IW   = 4;
    localparam int unsigned PW   = NB * BW;
    localparam int unsigned AW   = 6;
    localparam logic [CB*8-1:0] MASKS = 64'hC5_0F_FF_01_87_3F_1F_CF;

    logic          clk = 1'b0;
    logic          rst;
    logic          start;
    logic [NB-1:0] cp_block;
    logic          mem_rd_en;
    logic [1:0]    mem_rd_sel;
    logic [AW-1:0] mem_rd_addr;
    logic [15:0]   mem_rd_data;
    logic          busy;
    logic          done;
    logic [15:0]   checksum;
    logic [31:0]   id_packed;

    always #4 clk = ~clk;

    image_checksum #(
        .NUM_BLOCKS (NB),
        .BLOCK_WORDS(BW),
        .CFG_BYTES  (CB),
        .ID_WORDS   (IW),
        .CFG_MASK   (MASKS)
    ) dut (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .cp_block   (cp_block),
        .mem_rd_en  (mem_rd_en),
        .mem_rd_sel (mem_rd_sel),
        .mem_rd_addr(mem_rd_addr),
        .mem_rd_data(mem_rd_data),
        .busy       (busy),
        .done       (done),
        .checksum   (checksum),
        .id_packed  (id_packed)
    );

    // ---------------- memory model ----------------
    logic [15:0] prog_m [PW];
    logic [15:0] cfg_m  [CB];
    logic [15:0] id_m   [IW];

    int          rd_cnt;
    int          id_reads;
    int          order_err;
    logic        prev_en;
    logic [1:0]  prev_sel;
    logic [AW-1:0] prev_addr;

    always_ff @(posedge clk) begin
        if (mem_rd_en) begin
            case (mem_rd_sel)
                2'd0:    mem_rd_data <= prog_m[mem_rd_addr];
                2'd1:    mem_rd_data <= cfg_m[mem_rd_addr[2:0]];
                2'd2:    mem_rd_data <= id_m[mem_rd_addr[1:0]];
                default: mem_rd_data <= 16'hBEEF;
            endcase
        end else begin
            mem_rd_data <= 16'hDEAD;
        end
        if (rst || (start && !busy)) begin
            rd_cnt    <= 0;
            id_reads  <= 0;
            order_err <= 0;
            prev_en   <= 1'b0;
            prev_sel  <= 2'd0;
            prev_addr <= '0;
        end else begin
            prev_en <= mem_rd_en;
            if (mem_rd_en) begin
                rd_cnt    <= rd_cnt + 1;
                prev_sel  <= mem_rd_sel;
                prev_addr <= mem_rd_addr;
                if (mem_rd_sel == 2'd2) id_reads <= id_reads + 1;
                if (!prev_en) begin
                    if (mem_rd_sel != 2'd0 || mem_rd_addr != '0) order_err <= order_err + 1;
                end else if (mem_rd_sel == prev_sel) begin
                    if (mem_rd_addr != prev_addr + 1'b1) order_err <= order_err + 1;
                end else if (mem_rd_sel != prev_sel + 2'd1 || mem_rd_addr != '0) begin
                    order_err <= order_err + 1;
                end
            end
        end
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [15:0] sum;
        logic [15:0] raw;
        string       tag;
    } exp_t;

    exp_t sbq[$];
    int   n_cmp = 0;
    int   n_bad = 0;
    bit   finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin : monitor
        logic done_prev;
        exp_t e;
        done_prev = 1'b0;
        forever begin
            @(negedge clk);
            if (done && !done_prev) begin
                if (sbq.size() == 0) begin
                    check(1'b0, "R9 unexpected result", {16'h0, checksum}, 32'h0);
                end else begin
                    e = sbq.pop_front();
                    check(checksum == e.sum, e.tag, {16'h0, checksum}, {16'h0, e.sum});
                    check(id_packed == {e.raw, 16'h0000}, "R6 packed id", id_packed,
                          {e.raw, 16'h0000});
                end
            end
            done_prev = done;
        end
    end

    // ---------------- stimulus ----------------
    task automatic fill(input int kind, input logic [15:0] seed);
        for (int i = 0; i < PW; i++)
            prog_m[i] = (kind == 1) ? 16'hFFFF : (kind == 2) ? 16'h0000 : (16'((i + 1) * 40503) ^ seed);
        for (int i = 0; i < CB; i++)
            cfg_m[i] = (kind == 0) ? {seed[7:0], 8'(i * 37) ^ seed[15:8]} : 16'hFFFF;
        for (int i = 0; i < IW; i++)
            id_m[i] = (kind == 2) ? 16'h0000 : (kind == 1) ? 16'hFFFF : (16'(i * 4099) + seed);
    endtask

    task automatic model(input logic [NB-1:0] cp, output logic [15:0] s, output logic [15:0] r);
        s = 16'h0;
        r = 16'h0;
        for (int i = 0; i < PW; i++) begin
            r = r + prog_m[i];
            if (!cp[i / BW]) s = s + prog_m[i];
        end
        for (int i = 0; i < CB; i++) begin
            s = s + {8'h00, cfg_m[i][7:0] & MASKS[i*8 +: 8]};
            r = r + {8'h00, cfg_m[i][7:0] & MASKS[i*8 +: 8]};
        end
        if (|cp)
            for (int i = 0; i < IW; i++) s = s + id_m[i];
    endtask

    task automatic run(input string tag, input logic [NB-1:0] cp, input bit poke);
        exp_t e;
        int   cycles;
        int   n_rd;
        logic [15:0] held;
        model(cp, e.sum, e.raw);
        e.tag = tag;
        sbq.push_back(e);
        n_rd = PW + CB + ((|cp) ? IW : 0);
        @(negedge clk);
        start    = 1'b1;
        cp_block = cp;
        @(posedge clk);
        cycles = 0;
        forever begin
            @(negedge clk);
            start = 1'b0;
            if (poke && cycles == 10) begin
                start    = 1'b1;   // R9: ignored while busy
                cp_block = ~cp;    // R10: sampled value must stay in force
            end
            if (done || cycles > 400) break;
            @(posedge clk);
            cycles++;
        end
        start    = 1'b0;
        cp_block = cp;
        check(cycles == n_rd + 1, {"R7 latency ", tag}, cycles, n_rd + 1);
        check(rd_cnt == n_rd && order_err == 0, {"R7 read order ", tag},
              {rd_cnt[15:0], order_err[15:0]}, {n_rd[15:0], 16'h0});
        check(id_reads == ((|cp) ? IW : 0), {"R5 id reads ", tag}, id_reads,
              (|cp) ? IW : 0);
        held = checksum;
        repeat (5) @(negedge clk);
        check(done && checksum == held, {"R8 hold ", tag}, {15'h0, done, checksum},
              {15'h0, 1'b1, held});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin : main
        rst      = 1'b1;
        start    = 1'b0;
        cp_block = '0;
        fill(0, 16'h1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!busy && !done && !mem_rd_en && checksum == 16'h0 && id_packed == 32'h0,
              "R11 reset state", {busy, done, mem_rd_en, 13'h0, checksum}, 32'h0);

        run("R1 plain program sum", 4'b0000, 1'b0);
        run("R4 one protected block", 4'b0010, 1'b0);
        fill(0, 16'h5A5A);
        run("R5 all protected with ID", 4'b1111, 1'b0);
        fill(1, 16'h0000);
        run("R2 wraparound", 4'b0000, 1'b0);
        fill(2, 16'h0000);
        run("R3 masked config only", 4'b0000, 1'b0);
        fill(0, 16'h0F0F);
        run("R9 start during walk", 4'b0100, 1'b1);
        run("R10 restart from done", 4'b0000, 1'b0);
        check(sbq.size() == 0, "R9 result count", sbq.size(), 0);

        repeat (3) @(negedge clk);
        if (!finished) begin
            finished = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule